// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The host hands it one request at a time through a valid/ready port: a read or a write, a 15-bit word address and, for writes, one data byte. The controller plays the request out on the memory pins as a sequence of active-low strobes: chip select (CE), output enable (OE) and write enable (WE). It keeps the address steady for the whole access. It reports completion with a one-cycle done pulse, and for reads it also returns the byte it captured.

Every interval on the pins is a count of clock cycles set by a parameter, so the block works at any clock rate. Writes are WE-controlled with OE held high. Because the memory's output drivers stay off during a write, the cycle needs no extra time for them to release the bus. Write data is driven one cycle before WE falls and held one cycle after WE rises, which covers setup and hold against the rising edge that ends the write. The bidirectional data bus appears as three signals: data out, output enable and data in. A read that follows a write waits a set number of idle cycles, with everything released, before OE may fall. When no request is active, CE stays high so the memory can power down.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no request is in progress, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rd_data is 0 until the first read completes.
- R2: An accepted write holds CE low and OE high and drives WE low for exactly T_PWE_CYC cycles. The accepted byte is written at the accepted address. done rises T_PWE_CYC+2 cycles after the accepting clock edge.
- R3: An accepted read that does not follow a write takes one cycle with CE low before OE falls. OE then stays low for T_AA_CYC+1 cycles, and the byte on mem_dq_in is captured at the end of the last of them. done and rd_data appear T_AA_CYC+2 cycles after the accepting edge.
- R4: mem_addr equals the accepted address and does not change in any cycle where CE was also low in the cycle before.
- R5: mem_dq_oe is never 1 while OE is low, and is 1 only while a write sequence is in progress.
- R6: A read accepted when the previous completed request was a write completes T_TURN_CYC cycles later than R3 gives. OE does not fall until more than T_TURN_CYC cycles have passed since mem_dq_oe was last 1.
- R7: done is high for exactly one cycle, and req_ready is already 1 in that cycle, so a request held valid is accepted at the edge that ends the done cycle.
- R8: WE is never low while OE is low, and WE is low only while CE is low.
- R9: mem_dq_out does not change while WE stays low.
- R10: rd_data keeps its last read result through later write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the latest read |
| mem_addr | output | 15 | Address pins of the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 8 | Data seen on the bus |

## Verification
Two events can share a cycle. One is the completion pulse of one request. The other is the acceptance of the next request, because ready returns in the same idle cycle that carries done. The bench provokes this by keeping req_valid high across a chain of mixed writes and reads, so each new request is accepted at the edge that ends the previous done cycle. It then checks two things. First, the driver must see done high at the moment its request is taken. Second, every completion must still arrive at its computed cycle with the right data, including the turnaround delay when a read directly follows a write.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_SAMPLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURN
  } ctl_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // The timer holds a count minus one, so it needs bits for v-1.
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

  // Cycles from the accepting edge to the edge that raises done.
  function automatic int unsigned rd_latency(input int unsigned taa, input int unsigned turn,
                                             input bit after_wr);
    return taa + 2 + (after_wr ? turn : 0);
  endfunction

  function automatic int unsigned wr_latency(input int unsigned tpwe);
    return tpwe + 2;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int T_AA_CYC   = 2,
  parameter int T_PWE_CYC  = 2,
  parameter int T_TURN_CYC = 2,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cap_rd,
  output logic             done,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             st_idle,
  output logic             wr_phase
);

  localparam logic [CNT_W-1:0] LD_AA   = CNT_W'(T_AA_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PWE  = CNT_W'(T_PWE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(T_TURN_CYC - 1);

  ctl_state_e state_q, state_d;
  logic       last_wr_q;
  logic       done_q;

  assign st_idle   = (state_q == ST_IDLE);
  assign req_ready = st_idle;
  assign accept    = st_idle && req_valid;
  assign cap_rd    = (state_q == ST_RD_SAMPLE);
  assign wr_phase  = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE) ||
                     (state_q == ST_WR_HOLD);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else if (last_wr_q) begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = LD_TURN;
          end else begin
            state_d = ST_RD_SETUP;
          end
        end
      end
      ST_TURN:      if (tmr_expired) state_d = ST_RD_SETUP;
      ST_RD_SETUP: begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = LD_AA;
      end
      ST_RD_WAIT:   if (tmr_expired) state_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE: state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_PWE;
      end
      ST_WR_PULSE:  if (tmr_expired) state_d = ST_WR_HOLD;
      ST_WR_HOLD:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      last_wr_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RD_SAMPLE) || (state_q == ST_WR_HOLD);
      if (state_q == ST_WR_HOLD)   last_wr_q <= 1'b1;
      if (state_q == ST_RD_SAMPLE) last_wr_q <= 1'b0;
    end
  end

  assign done = done_q;

  // Pin strobes decoded from the state register only.
  always_comb begin
    ce_n  = 1'b1;
    oe_n  = 1'b1;
    we_n  = 1'b1;
    dq_oe = 1'b0;
    unique case (state_q)
      ST_RD_SETUP:  ce_n = 1'b0;
      ST_RD_WAIT,
      ST_RD_SAMPLE: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WR_SETUP,
      ST_WR_HOLD: begin
        ce_n  = 1'b0;
        dq_oe = 1'b1;
      end
      ST_WR_PULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_rd,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_rd) rd_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rd_data    = rd_q;

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int T_AA_CYC   = 2,
  parameter int T_PWE_CYC  = 2,
  parameter int T_TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CNT_W = cnt_width(max3(T_AA_CYC, T_PWE_CYC, T_TURN_CYC));

  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             cap_rd;
  logic             st_idle;
  logic             wr_phase;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctl_seq #(
    .T_AA_CYC   (T_AA_CYC),
    .T_PWE_CYC  (T_PWE_CYC),
    .T_TURN_CYC (T_TURN_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cap_rd      (cap_rd),
    .done        (done),
    .ce_n        (mem_ce_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .dq_oe       (mem_dq_oe),
    .st_idle     (st_idle),
    .wr_phase    (wr_phase)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cap_rd     (cap_rd),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              st_idle,
  input logic              wr_phase
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (ce_n && oe_n && we_n && !dq_oe));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ce_n && $past(!ce_n)) |-> $stable(addr));

  p_bus_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> wr_phase);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_we_needs_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  p_wdata_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !we_n && $past(!we_n)) |-> $stable(dq_out));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (mem_ce_n),
  .oe_n     (mem_oe_n),
  .we_n     (mem_we_n),
  .dq_oe    (mem_dq_oe),
  .dq_out   (mem_dq_out),
  .addr     (mem_addr),
  .done     (done),
  .st_idle  (st_idle),
  .wr_phase (wr_phase)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;

  localparam int T_AA   = 2;
  localparam int T_PWE  = 2;
  localparam int T_TURN = 2;

  typedef struct {
    bit        wr;
    bit [14:0] addr;
    bit [7:0]  data;
    int        due;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    finished = 0;
  item_t sb_q[$];
  bit [7:0] sb_mem [int];
  bit [7:0] bus_mem [int];
  bit    last_wr = 0;
  bit [7:0] last_rd = 8'h00;

  int prot_r4 = 0, prot_r5 = 0, prot_r6 = 0, prot_r8 = 0, prot_r9 = 0, prot_r7 = 0;
  int oe_low_cnt = 0;
  int since_drive = 100;
  logic prev_ce_n = 1, prev_we_n = 1, prev_oe_n = 1, prev_done = 0;
  logic [14:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;

  sram_ctl #(.T_AA_CYC(T_AA), .T_PWE_CYC(T_PWE), .T_TURN_CYC(T_TURN)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model and pin monitors, all sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      // write ends on the first falling-edge sample after WE or CE rises
      if (!prev_we_n && !prev_ce_n && (mem_we_n || mem_ce_n)) begin
        bus_mem[int'(mem_addr)] = mem_dq_out;
        if (sb_q.size() != 0) begin
          chk(mem_addr == sb_q[0].addr, "R2", "write address", mem_addr, sb_q[0].addr);
          chk(mem_dq_out == sb_q[0].data && mem_dq_oe, "R2", "write data", mem_dq_out,
              sb_q[0].data);
        end
      end
      if (!mem_ce_n && !prev_ce_n && mem_addr != prev_addr) prot_r4++;
      if (!mem_ce_n && sb_q.size() != 0 && mem_addr != sb_q[0].addr) prot_r4++;
      if (mem_dq_oe && !mem_oe_n) prot_r5++;
      if (!mem_we_n && (!mem_oe_n || mem_ce_n)) prot_r8++;
      if (!mem_we_n && !prev_we_n && mem_dq_out != prev_dq) prot_r9++;
      if (!mem_we_n && !mem_dq_oe) prot_r9++;
      if (done && prev_done) prot_r7++;
      if (!mem_oe_n && prev_oe_n && since_drive <= T_TURN) prot_r6++;
      since_drive = mem_dq_oe ? 0 : since_drive + 1;
      oe_low_cnt = mem_oe_n ? 0 : oe_low_cnt + 1;
      // data valid only after the access time has elapsed, garbage before
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        bit [7:0] v;
        v = bus_mem.exists(int'(mem_addr)) ? bus_mem[int'(mem_addr)] : 8'h00;
        mem_dq_in = (oe_low_cnt > T_AA) ? v : ~v;
      end else begin
        mem_dq_in = 8'h00;
      end
    end
    prev_ce_n = mem_ce_n;
    prev_we_n = mem_we_n;
    prev_oe_n = mem_oe_n;
    prev_addr = mem_addr;
    prev_dq   = mem_dq_out;
    prev_done = done;
  end

  // Scoreboard monitor: pops the expected item at every done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(0, "R7", "done with no request outstanding", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.wr) begin
          chk(cyc == it.due, "R2", "write done cycle", cyc, it.due);
          chk(rd_data == last_rd, "R10", "rd_data held over write", rd_data, last_rd);
        end else begin
          chk(cyc == it.due, "R3/R6", "read done cycle", cyc, it.due);
          chk(rd_data == it.data, "R3", "read data", rd_data, it.data);
          last_rd = it.data;
        end
      end
    end
  end

  // Driver: call at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input bit wr, input bit [14:0] a, input bit [7:0] d,
                       output bit saw_done);
    item_t it;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    saw_done = done;
    it.wr   = wr;
    it.addr = a;
    if (wr) begin
      it.data = d;
      it.due  = cyc + 1 + T_PWE + 2;
      sb_mem[int'(a)] = d;
    end else begin
      it.data = sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : 8'h00;
      it.due  = cyc + 1 + T_AA + 2 + (last_wr ? T_TURN : 0);
    end
    last_wr = wr;
    sb_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1",
        "idle pins released", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
  endtask

  initial begin
    bit sd;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_dq_oe && !done, "R1", "no drive, no done after reset", {mem_dq_oe, done}, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rd_data == 8'h00, "R1", "rd_data reset value", rd_data, 0);

    // isolated writes, corner addresses and data patterns (R2, R4, R9)
    issue(1, 15'h0000, 8'h3C, sd); drain();
    issue(1, 15'h7FFF, 8'hC3, sd); drain();
    issue(1, 15'h1234, 8'h00, sd); drain();
    issue(1, 15'h4321, 8'hFF, sd); drain();
    // first read after a write pays the turnaround (R6), the rest do not (R3)
    issue(0, 15'h4321, 8'h00, sd); drain();
    issue(0, 15'h1234, 8'h00, sd); drain();
    issue(0, 15'h7FFF, 8'h00, sd); drain();
    issue(0, 15'h0000, 8'h00, sd); drain();

    // back-to-back chain: acceptance falls in the done cycle (R7)
    issue(1, 15'h0055, 8'hA5, sd);
    issue(0, 15'h0055, 8'h00, sd);
    chk(sd, "R7", "read accepted in write done cycle", sd, 1);
    issue(1, 15'h0AAA, 8'h5A, sd);
    chk(sd, "R7", "write accepted in read done cycle", sd, 1);
    issue(0, 15'h0AAA, 8'h00, sd);
    chk(sd, "R7", "read after write in done cycle", sd, 1);
    issue(0, 15'h0055, 8'h00, sd);
    chk(sd, "R7", "read after read in done cycle", sd, 1);
    issue(1, 15'h7FFF, 8'h81, sd);
    issue(0, 15'h7FFF, 8'h00, sd);
    drain();

    chk(prot_r4 == 0, "R4", "address changes while selected", prot_r4, 0);
    chk(prot_r5 == 0, "R5", "drive while OE low", prot_r5, 0);
    chk(prot_r6 == 0, "R6", "OE fell inside turnaround", prot_r6, 0);
    chk(prot_r7 == 0, "R7", "done longer than one cycle", prot_r7, 0);
    chk(prot_r8 == 0, "R8", "WE strobe overlap", prot_r8, 0);
    chk(prot_r9 == 0, "R9", "write data moved under WE", prot_r9, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule